// File: doc/BRIEF.md
# Round-Robin Next-Grant Selector

This block takes a one-hot "current grant" vector and a request vector of the same width. It returns the one-hot grant that round-robin order picks next. The search starts at the bit just above the current holder, climbs toward the most significant bit, and wraps to bit 0. The first position whose request bit is set wins. When no request is set, the grant is all zeros and the valid flag is low. When the current vector is all zeros, the search begins at bit 0.

The selection is combinational and works in five steps:
- encode the current holder to an index;
- rotate the request vector right by that index plus one;
- find the lowest set bit of the rotated vector;
- add the offset back to the rotation modulo the slot count;
- decode the result to one-hot.

No full-width subtraction is used. A register holds the current grant. It loads the selected grant on a clock edge where the advance input is high and the selection is valid. A synchronous reset clears the register to zero. The slot count is a parameter, and nothing in the logic assumes eight slots.

Top module: `rr_next_grant`

## Requirements
- R1: Bit positions are numbered with bit 0 as the least significant. `nextGrant` has exactly the bit set at the first requesting position found by scanning upward from (index of `curGrant`) + 1 and wrapping past NUM_SLOTS-1 to 0. For example, with current 8'h04 and requests 8'h60 the grant is 8'h20. With current 8'h40 and requests 8'h0A the grant is 8'h02.
- R2: `nextGrant` never has a bit set at a position whose `reqMask` bit is clear.
- R3: `nextGrant` is always one-hot or all zeros, and `nextValid` is high exactly when `nextGrant` is non-zero.
- R4: When `reqMask` is all zeros, `nextGrant` is all zeros and `nextValid` is low.
- R5: When `curGrant` is all zeros, the grant is the lowest set bit of `reqMask`.
- R6: When the only requesting position is the current holder, the search wraps fully around and grants that same position again.
- R7: On a rising clock edge with `advance` high and `nextValid` high, `curGrant` takes the value `nextGrant` had before the edge.
- R8: On a rising clock edge with `advance` low, or with `nextValid` low, `curGrant` keeps its value.
- R9: On a rising clock edge with `rst` high, `curGrant` becomes all zeros, whatever `advance` is.
- R10: `curGrant` is always one-hot or all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Load the selected grant into the holder register |
| reqMask | input | NUM_SLOTS | Request bit per slot |
| curGrant | output | NUM_SLOTS | Registered current holder, one-hot or zero |
| nextGrant | output | NUM_SLOTS | Combinational next grant, one-hot or zero |
| nextValid | output | 1 | High when some request exists |

## Verification
The bench targets several corner cases:
- The wrap from the top slot to slot 0. A design that forgets the wrap returns zero or a bit below the holder.
- The lone-request-equals-holder case. An off-by-one rotation skips the holder and reports no grant.
- The all-zero holder. A design without the special case starts searching at bit 1 and misses a request at bit 0.
- An advance with no requests. A register that loads regardless of validity is wiped to zero.

Random request and advance sequences are compared against a loop-based scan kept in the bench.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef struct packed {
    logic clear;
    logic load;
  } grantStrobes_t;
endpackage

// File: rtl/rr_select_path.sv
module rr_select_path #(
  parameter int NUM_SLOTS = 8
) (
  input  logic [NUM_SLOTS-1:0] curVec,
  input  logic [NUM_SLOTS-1:0] reqVec,
  output logic [NUM_SLOTS-1:0] grantVec,
  output logic                 anyReq
);
  localparam int IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [IW-1:0] TOP_IDX = IW'(NUM_SLOTS - 1);
  localparam logic [IW:0]   SLOT_COUNT = (IW+1)'(NUM_SLOTS);

  logic [IW-1:0]        curIdx;
  logic [IW-1:0]        shiftAmt;
  logic [2*NUM_SLOTS-1:0] doubled;
  logic [2*NUM_SLOTS-1:0] shifted;
  logic [NUM_SLOTS-1:0] rotated;
  logic [IW-1:0]        offset;
  logic [IW:0]          sum;
  logic [IW-1:0]        absIdx;

  // Encode the holder's index; an empty holder counts as the top slot.
  always_comb begin
    logic hit;
    hit    = 1'b0;
    curIdx = TOP_IDX;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (curVec[i] && !hit) begin
        curIdx = IW'(i);
        hit    = 1'b1;
      end
    end
  end

  // The search starts one above the holder.
  assign shiftAmt = (curIdx == TOP_IDX) ? '0 : curIdx + 1'b1;

  // Rotate right through a doubled copy.
  assign doubled = {reqVec, reqVec};
  assign shifted = doubled >> shiftAmt;
  assign rotated = shifted[NUM_SLOTS-1:0];

  // Lowest set bit of the rotated vector.
  always_comb begin
    offset = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (rotated[i]) offset = IW'(i);
    end
  end
  assign anyReq = |rotated;

  // Offset back to an absolute position, modulo the slot count.
  assign sum    = {1'b0, offset} + {1'b0, shiftAmt};
  assign absIdx = (sum >= SLOT_COUNT) ? IW'(sum - SLOT_COUNT) : sum[IW-1:0];

  // Decode to one-hot.
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_decode
    assign grantVec[g] = anyReq && (absIdx == IW'(g));
  end
endmodule

// File: rtl/rr_grant_ctrl.sv
module rr_grant_ctrl
  import rr_pkg::*;
(
  input  logic          rst,
  input  logic          advance,
  input  logic          selValid,
  output grantStrobes_t strobes
);
  always_comb begin
    strobes.clear = rst;
    strobes.load  = !rst && advance && selValid;
  end
endmodule

// File: rtl/rr_grant_store.sv
module rr_grant_store
  import rr_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  grantStrobes_t        strobes,
  input  logic [NUM_SLOTS-1:0] loadVal,
  output logic [NUM_SLOTS-1:0] holder
);
  always_ff @(posedge clk) begin
    if (strobes.clear)     holder <= '0;
    else if (strobes.load) holder <= loadVal;
  end

  assert_reset_clears_R9: assert property (@(posedge clk)
    strobes.clear |=> holder == '0);
  assert_holder_onehot_R10: assert property (@(posedge clk) disable iff (strobes.clear)
    $onehot0(holder));
endmodule

// File: rtl/rr_next_grant.sv
module rr_next_grant
  import rr_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 advance,
  input  logic [NUM_SLOTS-1:0] reqMask,
  output logic [NUM_SLOTS-1:0] curGrant,
  output logic [NUM_SLOTS-1:0] nextGrant,
  output logic                 nextValid
);
  grantStrobes_t strobes;

  rr_select_path #(.NUM_SLOTS(NUM_SLOTS)) u_select (
    .curVec  (curGrant),
    .reqVec  (reqMask),
    .grantVec(nextGrant),
    .anyReq  (nextValid)
  );

  rr_grant_ctrl u_ctrl (
    .rst     (rst),
    .advance (advance),
    .selValid(nextValid),
    .strobes (strobes)
  );

  rr_grant_store #(.NUM_SLOTS(NUM_SLOTS)) u_store (
    .clk    (clk),
    .strobes(strobes),
    .loadVal(nextGrant),
    .holder (curGrant)
  );

  assert_grant_in_mask_R2: assert property (@(posedge clk) disable iff (rst)
    (nextGrant & ~reqMask) == '0);
  assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(nextGrant) && (nextValid == (nextGrant != '0)));
  assert_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (reqMask == '0) |-> (!nextValid && nextGrant == '0));
  assert_load_R7: assert property (@(posedge clk) disable iff (rst)
    (advance && nextValid) |=> curGrant == $past(nextGrant));
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(advance && nextValid) |=> $stable(curGrant));
endmodule

// File: tb/test_rr_next_grant.sv
module test_rr_next_grant;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         advance;
  logic [N-1:0] reqMask;
  logic [N-1:0] curGrant;
  logic [N-1:0] nextGrant;
  logic         nextValid;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #5 clk = ~clk;

  rr_next_grant #(.NUM_SLOTS(N)) i_rr_next_grant (
    .clk(clk), .rst(rst), .advance(advance), .reqMask(reqMask),
    .curGrant(curGrant), .nextGrant(nextGrant), .nextValid(nextValid)
  );

  // {current, requests, expected}
  localparam int NVEC = 12;
  localparam logic [3*N-1:0] VECS [NVEC] = '{
    {8'h04, 8'h60, 8'h20},  // R1 skip non-requesters
    {8'h40, 8'h0A, 8'h02},  // R1 wrap
    {8'h00, 8'h0A, 8'h02},  // R5 empty holder
    {8'h00, 8'h80, 8'h80},  // R5 only top requests
    {8'h10, 8'h10, 8'h10},  // R6 lone self request
    {8'h80, 8'h81, 8'h01},  // R1 wrap from top
    {8'h01, 8'h00, 8'h00},  // R4 idle
    {8'h08, 8'hFF, 8'h10},  // R1 neighbour
    {8'h80, 8'h00, 8'h00},  // R4 idle from top
    {8'h02, 8'h03, 8'h01},  // R1 full wrap to lower
    {8'h20, 8'h40, 8'h40},  // R1 adjacent
    {8'h01, 8'hFE, 8'h02}   // R1 lowest above
  };

  function automatic logic [N-1:0] refNext(input logic [N-1:0] cur, input logic [N-1:0] req);
    int start = 0;
    for (int i = 0; i < N; i++) if (cur[i]) start = (i + 1) % N;
    for (int k = 0; k < N; k++) begin
      int p = (start + k) % N;
      if (req[p]) return N'(1) << p;
    end
    return '0;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; advance = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  // Load a one-hot holder from reset by requesting only that slot.
  task automatic setHolder(input logic [N-1:0] v);
    doReset();
    if (v != '0) begin
      reqMask = v; advance = 1'b1;
      @(negedge clk); advance = 1'b0;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    failCount++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [N-1:0] model;
    rst = 1'b1; advance = 1'b0; reqMask = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1 check("R9 reset state", curGrant, '0);

    for (int v = 0; v < NVEC; v++) begin
      logic [N-1:0] c, r, e;
      {c, r, e} = VECS[v];
      setHolder(c);
      reqMask = r;
      #1;
      check("R1 table grant", nextGrant, e);
      check("R3 table valid", {7'b0, nextValid}, {7'b0, e != '0});
    end

    // R7 load on advance
    setHolder(8'h08);
    reqMask = 8'h21; advance = 1'b1;
    @(negedge clk); advance = 1'b0;
    check("R7 load", curGrant, 8'h20);
    // R8 advance with no request keeps holder
    reqMask = '0; advance = 1'b1;
    @(negedge clk); advance = 1'b0;
    check("R8 hold on invalid", curGrant, 8'h20);
    check("R4 idle grant", nextGrant, '0);
    // R8 no advance keeps holder
    reqMask = 8'hFF;
    @(negedge clk);
    check("R8 hold without advance", curGrant, 8'h20);
    // R9 reset beats advance
    rst = 1'b1; advance = 1'b1;
    @(negedge clk); rst = 1'b0; advance = 1'b0;
    check("R9 reset over advance", curGrant, '0);

    // Random sequence against the reference scan
    model = '0;
    for (int t = 0; t < 400; t++) begin
      reqMask = N'($urandom);
      if (t % 5 == 0) reqMask = '0;
      advance = $urandom_range(0, 1) == 1;
      #1;
      check("R1 random grant", nextGrant, refNext(model, reqMask));
      check("R2 grant within requests", nextGrant & ~reqMask, '0);
      if (advance && reqMask != '0) model = refNext(model, reqMask);
      @(negedge clk);
      check("R10 holder tracks", curGrant, model);
    end
    advance = 1'b0;
    summary();
  end
endmodule